// File: doc/BRIEF.md
# Integer Execute Unit with Logarithmic Shifter

This block is the integer execute stage of a five-stage 32-bit RISC pipeline. Each cycle it takes the two register operands (`rs` and `rt`), a 5-bit shift amount from the instruction word and an operation code. It computes one result and registers it at the next rising clock edge, together with a signed-overflow flag and a write-enable qualifier. All arithmetic is done combinationally in the cycle the operation is presented. The output register is the boundary into the following pipeline stage.

The unit supports several operation groups:
- add and subtract, in trapping-signed and wrapping-unsigned forms;
- the four bitwise operations;
- signed and unsigned set-on-less-than;
- six shifts, with the amount taken from either the instruction field or the low five bits of `rs`;
- leading-ones and leading-zeros counts;
- byte and halfword sign extension;
- a swap of the bytes within each halfword;
- two conditional moves, whose condition is reported on the write-enable qualifier.

Every shift passes through a chain of five 2:1 multiplexer stages that move the data by 1, 2, 4, 8 and 16 positions.

Top module: `alu_exec`

## Requirements
- R1: While `rst_i` is high at a rising edge, `result_o`, `ovf_o` and `wr_en_o` are cleared to 0. Otherwise the outputs show the operation presented before that edge, so the latency is exactly one cycle.
- R2: Op codes 0 (ADD), 1 (ADDU), 2 (SUB) and 3 (SUBU) give `rs+rt` or `rs-rt` modulo 2^32. The signed and unsigned forms give identical results.
- R3: `ovf_o` is 1 only for ADD or SUB when the true signed sum or difference lies outside [-2^31, 2^31-1]. It is 0 for every other op code, including ADDU and SUBU.
- R4: Op codes 4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR of `rs` and `rt`.
- R5: Op code 8 gives 1 when `rs < rt` as two's-complement values and 0 otherwise. Op code 9 makes the same comparison on unsigned values.
- R6: Op codes 10 (left logical), 11 (right logical) and 12 (right arithmetic) shift `rt` by `shamt_i`, for any amount from 0 to 31. Logical shifts fill the vacated bits with 0. The arithmetic shift fills them with bit 31 of `rt`.
- R7: Op codes 13, 14 and 15 perform the same three shifts, in that order, by `rs[4:0]`. Bits 31..5 of `rs` have no effect on the result.
- R8: Op code 16 returns the number of leading one bits of `rs`, and op code 17 the number of leading zero bits. Each count is in 0..32.
- R9: Op code 18 sign-extends `rt[7:0]` to 32 bits, and op code 19 sign-extends `rt[15:0]`.
- R10: Op code 20 returns `{rt[23:16], rt[31:24], rt[7:0], rt[15:8]}`.
- R11: Op code 21 (move-if-nonzero) and op code 22 (move-if-zero) return `rs`. `wr_en_o` is 1 exactly when `rt` is nonzero or zero, respectively.
- R12: Op codes 23 to 31 are unassigned. They give a result of 0, `ovf_o` 0 and `wr_en_o` 0.
- R13: `wr_en_o` is 1 for op codes 0 to 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| shamt_i | input | 5 | Shift amount from the instruction field |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed overflow |
| wr_en_o | output | 1 | Registered write-enable qualifier |

## Verification
The hardest conditions to reach are the ends of the shifter and counter ranges:
- a shift by exactly 31 with bit 31 set, where only the fill bits remain;
- a register-sourced shift whose `rs` carries nonzero upper bits;
- leading counts of exactly 0 and 32.

Plain operand patterns reach these only by chance. The stimulus therefore sweeps every shift amount against a set of corner operands, and deliberately sets garbage in `rs[31:5]`. It also builds operands with exactly k leading ones or zeros for every k from 0 to 32. A cross of all 32 op codes with sixteen corner and scrambled operands covers the overflow boundaries at the extreme signed values.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN  = 32;
    localparam int SH_W  = $clog2(XLEN);
    localparam int CNT_W = $clog2(XLEN + 1);

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLT  = 5'd8,
        OP_SLTU = 5'd9,
        OP_SLL  = 5'd10,
        OP_SRL  = 5'd11,
        OP_SRA  = 5'd12,
        OP_SLLV = 5'd13,
        OP_SRLV = 5'd14,
        OP_SRAV = 5'd15,
        OP_CLO  = 5'd16,
        OP_CLZ  = 5'd17,
        OP_SEB  = 5'd18,
        OP_SEH  = 5'd19,
        OP_WSBH = 5'd20,
        OP_MOVN = 5'd21,
        OP_MOVZ = 5'd22
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            ovf;
        logic            wen;
    } alu_out_t;

    function automatic logic [XLEN-1:0] sext_byte(input logic [XLEN-1:0] v);
        return {{(XLEN-8){v[7]}}, v[7:0]};
    endfunction

    function automatic logic [XLEN-1:0] sext_half(input logic [XLEN-1:0] v);
        return {{(XLEN-16){v[15]}}, v[15:0]};
    endfunction

    function automatic logic [XLEN-1:0] swap_in_halves(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int h = 0; h < XLEN / 16; h++) begin
            r[h*16 +: 8]     = v[h*16 + 8 +: 8];
            r[h*16 + 8 +: 8] = v[h*16 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;

    assign b_eff = sub_i ? ~b_i : b_i;
    assign sum_o = a_i + b_eff + W'(sub_i);
    assign ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    input  logic          left_i,
    input  logic          arith_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] stg [AW+1];
    logic         fill;

    assign fill   = arith_i & data_i[W-1];
    assign stg[0] = data_i;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [W-1:0] moved;
        assign moved      = left_i ? {stg[k][W-S-1:0], {S{1'b0}}}
                                   : {{S{fill}}, stg[k][W-1:S]};
        assign stg[k+1]   = amt_i[k] ? moved : stg[k];
    end

    assign data_o = stg[AW];
endmodule

// File: rtl/alu_lead_count.sv
module alu_lead_count #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val_i,
    input  logic          ones_i,
    output logic [CW-1:0] count_o
);
    logic [W-1:0] scan;

    assign scan = ones_i ? ~val_i : val_i;

    always_comb begin
        count_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (scan[i]) count_o = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [4:0]      op_i,
    input  logic [XLEN-1:0] rs_i,
    input  logic [XLEN-1:0] rt_i,
    input  logic [SH_W-1:0] shamt_i,
    output logic [XLEN-1:0] result_o,
    output logic            ovf_o,
    output logic            wr_en_o
);
    alu_op_e         op;
    logic            is_sub;
    logic [XLEN-1:0] sum;
    logic            sum_ovf;
    logic [SH_W-1:0] sh_amt;
    logic            sh_left;
    logic            sh_arith;
    logic [XLEN-1:0] sh_out;
    logic            cnt_ones;
    logic [CNT_W-1:0] cnt;
    alu_out_t        nxt;
    alu_out_t        q;

    assign op       = alu_op_e'(op_i);
    assign is_sub   = (op == OP_SUB) || (op == OP_SUBU);
    assign sh_amt   = (op == OP_SLLV || op == OP_SRLV || op == OP_SRAV)
                      ? rs_i[SH_W-1:0] : shamt_i;
    assign sh_left  = (op == OP_SLL) || (op == OP_SLLV);
    assign sh_arith = (op == OP_SRA) || (op == OP_SRAV);
    assign cnt_ones = (op == OP_CLO);

    alu_addsub #(.W(XLEN)) u_addsub (
        .a_i   (rs_i),
        .b_i   (rt_i),
        .sub_i (is_sub),
        .sum_o (sum),
        .ovf_o (sum_ovf)
    );

    alu_shift #(.W(XLEN), .AW(SH_W)) u_shift (
        .data_i  (rt_i),
        .amt_i   (sh_amt),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .data_o  (sh_out)
    );

    alu_lead_count #(.W(XLEN), .CW(CNT_W)) u_count (
        .val_i   (rs_i),
        .ones_i  (cnt_ones),
        .count_o (cnt)
    );

    always_comb begin
        nxt.value = '0;
        nxt.ovf   = 1'b0;
        nxt.wen   = 1'b1;
        case (op)
            OP_ADD, OP_SUB: begin
                nxt.value = sum;
                nxt.ovf   = sum_ovf;
            end
            OP_ADDU, OP_SUBU: nxt.value = sum;
            OP_AND:  nxt.value = rs_i & rt_i;
            OP_OR:   nxt.value = rs_i | rt_i;
            OP_XOR:  nxt.value = rs_i ^ rt_i;
            OP_NOR:  nxt.value = ~(rs_i | rt_i);
            OP_SLT:  nxt.value = {{(XLEN-1){1'b0}}, $signed(rs_i) < $signed(rt_i)};
            OP_SLTU: nxt.value = {{(XLEN-1){1'b0}}, rs_i < rt_i};
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV: nxt.value = sh_out;
            OP_CLO, OP_CLZ: nxt.value = XLEN'(cnt);
            OP_SEB:  nxt.value = sext_byte(rt_i);
            OP_SEH:  nxt.value = sext_half(rt_i);
            OP_WSBH: nxt.value = swap_in_halves(rt_i);
            OP_MOVN: begin
                nxt.value = rs_i;
                nxt.wen   = |rt_i;
            end
            OP_MOVZ: begin
                nxt.value = rs_i;
                nxt.wen   = ~|rt_i;
            end
            default: nxt.wen = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= nxt;
    end

    assign result_o = q.value;
    assign ovf_o    = q.ovf;
    assign wr_en_o  = q.wen;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
    import alu_pkg::*;
(
    input logic            clk_i,
    input logic            rst_i,
    input logic [4:0]      op_i,
    input logic [XLEN-1:0] rs_i,
    input logic [XLEN-1:0] rt_i,
    input logic [SH_W-1:0] shamt_i,
    input logic [XLEN-1:0] result_o,
    input logic            ovf_o,
    input logic            wr_en_o
);
    logic live;
    always_ff @(posedge clk_i) live <= !rst_i;

    // R3: unsigned and non-arithmetic ops never flag overflow
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && $past(op_i) != 5'd0 && $past(op_i) != 5'd2) |-> !ovf_o);

    // R8: leading counts stay within 0..32
    p_count_range_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && ($past(op_i) == 5'd16 || $past(op_i) == 5'd17)) |-> result_o <= 32);

    // R11: move-if-nonzero carries rs and its condition
    p_movn_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && $past(op_i) == 5'd21) |->
            (result_o == $past(rs_i) && wr_en_o == ($past(rt_i) != 0)));

    // R11: move-if-zero carries rs and its condition
    p_movz_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && $past(op_i) == 5'd22) |->
            (result_o == $past(rs_i) && wr_en_o == ($past(rt_i) == 0)));

    // R9: byte extension keeps the low byte and replicates its sign
    p_sext_byte_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && $past(op_i) == 5'd18) |->
            (result_o[7:0] == $past(rt_i[7:0]) &&
             (result_o[31:7] == '0 || result_o[31:7] == '1)));

    // R6: arithmetic shift keeps the sign bit
    p_sra_sign_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && ($past(op_i) == 5'd12 || $past(op_i) == 5'd15)) |->
            result_o[31] == $past(rt_i[31]));

    // R12: unassigned codes write nothing
    p_unassigned_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && $past(op_i) > 5'd22) |-> (!wr_en_o && result_o == '0));

    // R13: assigned non-move codes always write
    p_write_r13: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && $past(op_i) <= 5'd20) |-> wr_en_o);
endmodule

bind alu_exec alu_exec_chk u_chk (.*);

// File: tb/alu_exec_tb.sv
module alu_exec_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  op;
    logic [31:0] rs, rt;
    logic [4:0]  shamt;
    logic [31:0] result;
    logic        ovf, wen;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    alu_exec u_dut (
        .clk_i(clk), .rst_i(rst), .op_i(op), .rs_i(rs), .rt_i(rt),
        .shamt_i(shamt), .result_o(result), .ovf_o(ovf), .wr_en_o(wen)
    );

    function automatic logic [31:0] pat(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h0000_FFFF;
            6: return 32'h0000_8000;
            7: return 32'h0000_0080;
            8: return 32'h1234_5678;
            9: return 32'h0F0F_00F0;
            default: return 32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0F3C;
        endcase
    endfunction

    function automatic string tag_of(input int o);
        if (o <= 3)  return "R2";
        if (o <= 7)  return "R4";
        if (o <= 9)  return "R5";
        if (o <= 12) return "R6";
        if (o <= 15) return "R7";
        if (o <= 17) return "R8";
        if (o <= 19) return "R9";
        if (o == 20) return "R10";
        if (o <= 22) return "R11";
        return "R12";
    endfunction

    function automatic int lead(input logic [31:0] v, input logic bitv);
        int n = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i] != bitv) return n;
            n++;
        end
        return n;
    endfunction

    task automatic model(input int o, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sa, output logic [31:0] r,
                         output logic v, output logic w);
        longint s;
        int amt;
        r = 0; v = 0; w = (o <= 20);
        amt = (o >= 13 && o <= 15) ? int'(a[4:0]) : int'(sa);
        case (o)
            0, 1: begin r = a + b; s = longint'($signed(a)) + longint'($signed(b)); end
            2, 3: begin r = a - b; s = longint'($signed(a)) - longint'($signed(b)); end
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            7: r = ~(a | b);
            8: r = ($signed(a) < $signed(b)) ? 1 : 0;
            9: r = (a < b) ? 1 : 0;
            10, 13: r = b << amt;
            11, 14: r = b >> amt;
            12, 15: r = $unsigned($signed(b) >>> amt);
            16: r = 32'(lead(a, 1'b1));
            17: r = 32'(lead(a, 1'b0));
            18: r = 32'($signed(b[7:0]));
            19: r = 32'($signed(b[15:0]));
            20: r = {b[23:16], b[31:24], b[7:0], b[15:8]};
            21: begin r = a; w = (b != 0); end
            22: begin r = a; w = (b == 0); end
            default: ;
        endcase
        if (o == 0 || o == 2) v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endtask

    task automatic apply(input int o, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sa);
        logic [31:0] er;
        logic ev, ew;
        @(negedge clk);
        op = 5'(o); rs = a; rt = b; shamt = sa;
        model(o, a, b, sa, er, ev, ew);
        @(negedge clk);
        n_checks++;
        if (result !== er) begin
            n_fail++;
            $display("FAIL %s op=%0d rs=%h rt=%h sa=%0d result actual=%h expected=%h",
                     tag_of(o), o, a, b, sa, result, er);
        end
        n_checks++;
        if (ovf !== ev) begin
            n_fail++;
            $display("FAIL R3 op=%0d rs=%h rt=%h ovf actual=%b expected=%b", o, a, b, ovf, ev);
        end
        n_checks++;
        if (wen !== ew) begin
            n_fail++;
            $display("FAIL %s op=%0d rt=%h wr_en actual=%b expected=%b",
                     (o >= 21 && o <= 22) ? "R11" : (o > 22 ? "R12" : "R13"),
                     o, b, wen, ew);
        end
    endtask

    initial begin
        rst = 1'b1; op = 5'd0; rs = 32'd5; rt = 32'd7; shamt = 5'd3;
        @(negedge clk); @(negedge clk);
        // R1: reset clears every output
        n_checks++;
        if (result !== 0 || ovf !== 0 || wen !== 0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual=%h/%b/%b expected=0/0/0", result, ovf, wen);
        end
        rst = 1'b0;

        // cross of every op code with corner operands (R2..R5, R9..R13)
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    apply(o, pat(i), pat(j), 5'((i * 7 + j) & 31));

        // R6 / R7: every shift amount, garbage in rs[31:5] for register-sourced shifts
        for (int o = 10; o <= 15; o++)
            for (int i = 0; i < 12; i++)
                for (int s = 0; s < 32; s++)
                    apply(o, (pat(i + 3) & ~32'h1F) | 32'(s), pat(i), 5'(s));

        // R8: exact leading run lengths 0..32
        for (int k = 0; k <= 32; k++) begin
            apply(16, ~(32'hFFFF_FFFF >> k), 32'h0, 5'd0);
            apply(17, 32'hFFFF_FFFF >> k, 32'h0, 5'd0);
        end

        // R1: reset mid-stream clears outputs again
        @(negedge clk);
        op = 5'd2; rs = 32'h8000_0000; rt = 32'h1; rst = 1'b1;
        @(negedge clk);
        n_checks++;
        if (result !== 0 || ovf !== 0 || wen !== 0) begin
            n_fail++;
            $display("FAIL R1 mid reset actual=%h/%b/%b expected=0/0/0", result, ovf, wen);
        end
        rst = 1'b0;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule